// File: doc/BRIEF.md
# Serial Debug Register Access Chain

This block is a 38-bit serial data register that sits behind a JTAG TAP. It gives an external debugger read and write access to a bank of up to 32 on-chip debug registers, each 32 bits wide. The debugger shifts in one frame that holds a command flag, a register address and a data word. When the TAP enters Update-DR, the block carries out the command. A write stores the data word in the addressed register. A read copies the addressed register into the data field of the chain, so that the next scan pass returns it on TDO.

The TAP controller is outside the block. It supplies one level signal per DR state (Capture, Shift, Update), a select for this chain, and a flag that says the TAP holds the INTEST instruction. All of these are sampled on the block clock. The register bank is modelled as plain storage with `NUM_REGS` implemented entries. Any address at or above `NUM_REGS` has no register behind it.

Top module: `dbg_access_chain`

## Requirements
- R1: After reset the chain holds all zeros, every bank register reads zero, `tdo` is 0 and neither `wr_pulse` nor `rd_pulse` is high.
- R2: While the chain is active (`chain_sel` and `intest_mode` both high) and `shift_dr` is high, each clock moves the chain one place toward TDO. `tdi` enters bit 37 and `tdo` shows bit 0. A full pass takes 38 clocks.
- R3: The frame fields are fixed. Bit 37 is the command, with 1 meaning write and 0 meaning read. Bits 36:32 hold the register address, with bit 32 as the LSB. Bits 31:0 hold data, with bit 0 as the LSB. Bit 0 is therefore the first bit shifted in and the first bit shifted out.
- R4: On the first active clock with `update_dr` high, a write command to a mapped address stores the data field in that register, and `wr_pulse` is high for exactly that one cycle.
- R5: On the same entry cycle, a read command loads the addressed register into chain bits 31:0 and leaves bits 37:32 as they were. `rd_pulse` is high for that one cycle, and the following scan pass returns the value on `tdo`.
- R6: `capture_dr` has no effect. The chain keeps its contents, so the next pass returns the bits last shifted in.
- R7: When `chain_sel` or `intest_mode` is low, shifting and updates are ignored, the chain and the bank stay unchanged, and `tdo` is 0.
- R8: An address at or above `NUM_REGS` (default 24) reads as zero. A write to it changes no register and raises no `wr_pulse`.
- R9: `update_dr` held high for several cycles performs exactly one access.
- R10: If `update_dr` rises in a cycle where `shift_dr` is also high, the access is carried out on the frame as it stood before that cycle, and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (TCK domain) |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_sel | input | 1 | This chain is the selected data register |
| intest_mode | input | 1 | TAP holds the INTEST instruction |
| capture_dr | input | 1 | TAP is in Capture-DR (no effect) |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, chain bit 0 |
| wr_pulse | output | 1 | One-cycle register write strobe |
| rd_pulse | output | 1 | One-cycle register read strobe |

## Verification
Two events can land on the same clock: the entry into Update-DR, and a shift step. The bench forces this by raising `shift_dr` and `update_dr` together right after a full write frame has been scanned in, with `tdi` held at 1. It then judges the outcome in two ways. The next pass must return the frame unshifted, and a later readback of the target register must show the data that was written. A behavioural model, built on a bit queue and an integer array, predicts `tdo` and both strobes on every clock, so any collision or held-update error shows up as a mismatch.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;

    localparam int unsigned DEF_DATA_W   = 32;
    localparam int unsigned DEF_ADDR_W   = 5;
    localparam int unsigned DEF_NUM_REGS = 24;

    // Command flag carried in the top bit of a frame.
    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } dbg_cmd_e;

endpackage

// File: rtl/dbg_chain_ctrl.sv
module dbg_chain_ctrl
    import dbg_chain_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned NUM_REGS = DEF_NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_sel,
    input  logic              intest_mode,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              frame_cmd,
    input  logic [ADDR_W-1:0] frame_addr,
    output logic              active,
    output logic              shift_en,
    output logic              upd_entry,
    output logic              wr_pulse,
    output logic              rd_pulse
);

    localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W+1)'(NUM_REGS);

    typedef struct packed {
        logic upd_seen;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        addr_hit;
    dbg_cmd_e    cmd;

    always_comb begin
        cmd       = dbg_cmd_e'(frame_cmd);
        active    = chain_sel & intest_mode;
        addr_hit  = ({1'b0, frame_addr} < ADDR_LIMIT);
        upd_entry = active & update_dr & ~st_q.upd_seen;
        shift_en  = active & shift_dr;
        wr_pulse  = upd_entry & (cmd == CMD_WRITE) & addr_hit;
        rd_pulse  = upd_entry & (cmd == CMD_READ);
        st_d          = st_q;
        st_d.upd_seen = active & update_dr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R9
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && rd_pulse)); // R3

endmodule

// File: rtl/dbg_chain_shift.sv
module dbg_chain_shift
    import dbg_chain_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               shift_en,
    input  logic                               upd_entry,
    input  logic                               rd_load,
    input  logic                               tdi,
    input  logic [DATA_W-1:0]                  rd_data,
    output logic [1+ADDR_W+DATA_W-1:0]         chain
);

    localparam int unsigned CHAIN_W = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic [CHAIN_W-1:0] bits;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_entry) begin
            // Update entry wins over a coincident shift step.
            if (rd_load) begin
                st_d.bits[DATA_W-1:0] = rd_data;
            end
        end else if (shift_en) begin
            st_d.bits = {tdi, st_q.bits[CHAIN_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain = st_q.bits;

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !upd_entry) |=> (chain[CHAIN_W-2:0] == $past(chain[CHAIN_W-1:1]))); // R2
    AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_entry && rd_load) |=> (chain[DATA_W-1:0] == $past(rd_data))); // R5
    AST_READ_KEEPS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        upd_entry |=> (chain[CHAIN_W-1:DATA_W] == $past(chain[CHAIN_W-1:DATA_W]))); // R10

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_chain_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned NUM_REGS = DEF_NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_REGS-1:0][DATA_W-1:0] cells;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        logic [DATA_W-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en && (addr == IDX)) begin
                cell_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign cells[g] = cell_q;
    end

    // Unimplemented addresses fall through to zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_data = cells[i];
            end
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cells)); // R4

endmodule

// File: rtl/dbg_access_chain.sv
module dbg_access_chain
    import dbg_chain_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned NUM_REGS = DEF_NUM_REGS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chain_sel,
    input  logic intest_mode,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic tdi,
    output logic tdo,
    output logic wr_pulse,
    output logic rd_pulse
);

    localparam int unsigned CHAIN_W  = 1 + ADDR_W + DATA_W;
    localparam int unsigned CMD_BIT  = CHAIN_W - 1;
    localparam int unsigned ADDR_LSB = DATA_W;

    logic [CHAIN_W-1:0] chain;
    logic [DATA_W-1:0]  bank_rd;
    logic               active;
    logic               shift_en;
    logic               upd_entry;

    dbg_chain_ctrl #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .chain_sel   (chain_sel),
        .intest_mode (intest_mode),
        .shift_dr    (shift_dr),
        .update_dr   (update_dr),
        .frame_cmd   (chain[CMD_BIT]),
        .frame_addr  (chain[ADDR_LSB +: ADDR_W]),
        .active      (active),
        .shift_en    (shift_en),
        .upd_entry   (upd_entry),
        .wr_pulse    (wr_pulse),
        .rd_pulse    (rd_pulse)
    );

    dbg_chain_shift #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .upd_entry (upd_entry),
        .rd_load   (rd_pulse),
        .tdi       (tdi),
        .rd_data   (bank_rd),
        .chain     (chain)
    );

    dbg_reg_bank #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_pulse),
        .addr    (chain[ADDR_LSB +: ADDR_W]),
        .wr_data (chain[DATA_W-1:0]),
        .rd_data (bank_rd)
    );

    assign tdo = active ? chain[0] : 1'b0;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(chain_sel && intest_mode) |=> $stable(chain)); // R7
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_dr && !shift_dr && !update_dr) |=> $stable(chain)); // R6

endmodule

// File: tb/dbg_access_chain_test.sv
module dbg_access_chain_test;

    localparam int NREG = 24;
    localparam int CW   = 38;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic chain_sel = 1'b1, intest_mode = 1'b1;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic tdo, wr_pulse, rd_pulse;

    dbg_access_chain #(.NUM_REGS(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .intest_mode(intest_mode),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse)
    );

    int compared = 0, mismatched = 0, wr_cnt = 0;
    bit started = 0;
    bit q[$];
    int unsigned mdl [32];
    bit mprev;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned m_addr();
        int unsigned a = 0;
        for (int k = 0; k < 5; k++) a |= int'(q[32+k]) << k;
        return a;
    endfunction

    function automatic int unsigned m_data();
        int unsigned d = 0;
        for (int k = 0; k < 32; k++) d |= int'(q[k]) << k;
        return d;
    endfunction

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            for (int k = 0; k < CW; k++) q.push_back(1'b0);
            for (int k = 0; k < 32; k++) mdl[k] = 0;
            mprev = 0;
        end else begin
            bit act, entry;
            act   = chain_sel & intest_mode;
            entry = act & update_dr & !mprev;
            if (entry) begin
                if (q[37] && m_addr() < NREG) mdl[m_addr()] = m_data();
                if (!q[37]) begin
                    int unsigned v;
                    v = (m_addr() < NREG) ? mdl[m_addr()] : 0;
                    for (int k = 0; k < 32; k++) q[k] = v[k];
                end
            end else if (act && shift_dr) begin
                void'(q.pop_front());
                q.push_back(tdi);
            end
            mprev = act & update_dr;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            bit act, entry;
            #2;
            act   = chain_sel & intest_mode;
            entry = act & update_dr & !mprev;
            chk("R2 tdo", tdo, act ? q[0] : 1'b0);
            chk("R4 wr_pulse", wr_pulse, entry & q[37] & (m_addr() < NREG));
            chk("R5 rd_pulse", rd_pulse, entry & !q[37]);
            if (wr_pulse) wr_cnt++;
        end
    end

    task automatic scan(input logic [CW-1:0] f, output logic [CW-1:0] o);
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            shift_dr = 1'b1;
            tdi = f[i];
            #1 o[i] = tdo;
        end
        @(negedge clk);
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic do_update(input int hold);
        @(negedge clk);
        update_dr = 1'b1;
        repeat (hold - 1) @(negedge clk);
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    task automatic frame(input logic cmd, input logic [4:0] a, input logic [31:0] d,
                         output logic [CW-1:0] o);
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0;
        scan({cmd, a, d}, o);
        do_update(1);
    endtask

    task automatic read_reg(input logic [4:0] a, output logic [31:0] v);
        logic [CW-1:0] o;
        frame(1'b0, a, 32'h0, o);
        frame(1'b0, a, 32'h0, o);
        chk("R3 returned command bit", o[37], 1'b0);
        chk("R3 returned address", o[36:32], a);
        v = o[31:0];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0]   v;
        logic [CW-1:0] o;
        int            w0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 tdo after reset", tdo, 1'b0);
        chk("R1 wr_pulse after reset", wr_pulse, 1'b0);
        chk("R1 rd_pulse after reset", rd_pulse, 1'b0);
        started = 1;
        read_reg(5'd3, v);        chk("R1 reg3 reset value", v, 32'h0);
        read_reg(5'(NREG-1), v);  chk("R1 top reg reset value", v, 32'h0);

        // R4 / R5 write then read back
        frame(1'b1, 5'd5, 32'hDEADBEEF, o);
        frame(1'b1, 5'd0, 32'h00000001, o);
        frame(1'b1, 5'(NREG-1), 32'h80000000, o);
        read_reg(5'd5, v);        chk("R4 R5 reg5 readback", v, 32'hDEADBEEF);
        read_reg(5'd0, v);        chk("R4 R5 reg0 readback", v, 32'h00000001);
        read_reg(5'(NREG-1), v);  chk("R4 R5 top reg readback", v, 32'h80000000);

        // R2 / R6: pass returns previous contents, capture changes nothing
        scan(38'h2A_5A5A_A5A5, o);
        @(negedge clk); capture_dr = 1'b1;
        repeat (3) @(negedge clk);
        capture_dr = 1'b0;
        scan(38'h15_1234_5678, o);
        chk("R6 capture left chain intact", o, 38'h2A_5A5A_A5A5);
        scan(38'h0, o);
        chk("R2 full pass returns shifted-in bits", o, 38'h15_1234_5678);

        // R8 unmapped address
        w0 = wr_cnt;
        frame(1'b1, 5'd30, 32'h00001234, o);
        chk("R8 no wr_pulse for unmapped", wr_cnt - w0, 0);
        read_reg(5'd30, v);       chk("R8 unmapped reads zero", v, 32'h0);
        read_reg(5'(30 - 32 + NREG), v);
        chk("R8 aliased register untouched", v, 32'h0);

        // R7 deselected / not INTEST
        chain_sel = 1'b0;
        frame(1'b1, 5'd9, 32'hAAAA5555, o);
        chk("R7 tdo quiet when deselected", o, 38'h0);
        chain_sel = 1'b1;
        read_reg(5'd9, v);        chk("R7 deselected write ignored", v, 32'h0);
        intest_mode = 1'b0;
        frame(1'b1, 5'd10, 32'h0F0F0F0F, o);
        intest_mode = 1'b1;
        read_reg(5'd10, v);       chk("R7 non-INTEST write ignored", v, 32'h0);

        // R9 held update
        w0 = wr_cnt;
        scan({1'b1, 5'd12, 32'hCAFEF00D}, o);
        do_update(4);
        chk("R9 one write for held update", wr_cnt - w0, 1);
        read_reg(5'd12, v);       chk("R9 held update value", v, 32'hCAFEF00D);

        // R10 update and shift in the same cycle
        scan({1'b1, 5'd7, 32'h13579BDF}, o);
        @(negedge clk);
        shift_dr = 1'b1; update_dr = 1'b1; tdi = 1'b1;
        @(negedge clk);
        shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
        scan({1'b0, 5'd7, 32'h0}, o);
        chk("R10 chain not shifted on update", o, {1'b1, 5'd7, 32'h13579BDF});
        do_update(1);
        scan(38'h0, o);
        chk("R10 write performed on collision", o[31:0], 32'h13579BDF);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule